// File: doc/BRIEF.md
# Grouped Converter Serial Readout Receiver

This block runs the readout of one group of four pixel converters whose results share a single serial data line. A read request starts a burst of serial clock pulses at half the system clock rate, so a 100 MHz system clock gives a 50 MHz serial clock. The first pulse of the burst only starts the conversion. The pulses after it shift the four results out, one bit per pulse. The block captures each bit on the falling edge of the serial clock, which is the edge opposite the one on which the converter launches it. After the last bit it presents all four channel words together with a one-cycle strobe. One instance serves one sensor, so a two-sensor plane uses two instances.

The block has two sample formats. In the narrow format each channel sends 16 bits and the burst is 65 pulses long. In the wide format each channel sends 18 bits and the burst is 73 pulses long. The wide format keeps only the middle 16 bits of each sample: the top bit carries no information when the converter is used single-ended, and the bottom bit is dropped.

Top module: `adc_group_rx`

## Requirements
- R1: While reset is held, and after it is released, `sclk_o`, `busy_o`, `pix_valid_o` and `overrun_o` are 0 and `pix_data_o` is all zeros.
- R2: `sclk_o` stays low whenever no burst is running. The clock edge that accepts a request drives `sclk_o` high. During the burst, each pulse is high for one system clock cycle and then low for one.
- R3: A burst has exactly 1 + 4×16 = 65 pulses in the narrow format (`wide_mode_i` = 0) and exactly 1 + 4×18 = 73 pulses in the wide format (`wide_mode_i` = 1).
- R4: The first pulse carries no data. Data bit k of the frame (counting from 0) is the value on `sdata_i` at the falling edge of pulse k+1.
- R5: In the narrow format the frame holds channel 0 first, then channels 1, 2 and 3, each sent MSB first. Channel c appears on `pix_data_o[16*c +: 16]`.
- R6: In the wide format each channel sends an 18-bit sample MSB first, in the same channel order. The output word is bits 16 down to 1 of that sample, so sample bits 17 and 0 have no effect on the output.
- R7: `pix_valid_o` goes high for exactly one cycle, in the cycle after the clock edge that ends the last pulse, which is 2×pulses cycles after the accepting edge. `pix_data_o` changes only in that cycle and holds its value until the next one.
- R8: A request that arrives while `busy_o` is high raises `overrun_o` for exactly one cycle, one cycle later. The request is otherwise ignored: the current burst keeps its length and no further burst follows.
- R9: The format is taken from `wide_mode_i` on the edge that accepts the request. Changes to `wide_mode_i` during a burst do not affect that burst.
- R10: `busy_o` goes high on the accepting edge and falls on the same edge on which `pix_valid_o` rises. A request made in the cycle in which `pix_valid_o` is high is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, twice the serial clock rate |
| rst | input | 1 | Synchronous active-high reset |
| rd_req_i | input | 1 | Read request, one per cycle in which it is high |
| wide_mode_i | input | 1 | 0: 16-bit samples, 1: 18-bit samples trimmed to 16 bits |
| sdata_i | input | 1 | Serial data returned by the converter group |
| sclk_o | output | 1 | Serial clock to the converter group |
| busy_o | output | 1 | A burst is in progress |
| pix_valid_o | output | 1 | One-cycle strobe: the channel words are new |
| pix_data_o | output | 64 | Four channel words, channel c at bits 16c+15 down to 16c |
| overrun_o | output | 1 | One-cycle flag: a request arrived during a burst |

## Verification
The frame-complete strobe and the overrun flag can fall in the same cycle. This happens when a request arrives in the last cycle of a burst, while the final pulse is high. The bench places a request exactly there in both formats. It expects `pix_valid_o` and `overrun_o` to be high together, the words to match the frame already in flight, and the next cycle to show the block idle with no second burst. A request placed in the strobe cycle itself must instead start a new burst at once, and the bench judges this by the new frame's length and content.

// File: rtl/adcgrp_pkg.sv
package adcgrp_pkg;

    // Sample format carried by the serial frame
    typedef enum logic {
        FMT_NARROW = 1'b0,
        FMT_WIDE   = 1'b1
    } fmt_e;

    // Burst sequencer state
    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_RUN  = 1'b1
    } seq_e;

    // Strobes from the sequencer to the capture path
    typedef struct packed {
        logic sample;   // falling serial edge that carries a data bit
        logic last;     // falling edge of the final pulse
    } strobe_t;

    // Extra bits in a wide sample: one guard bit on top, one dropped at the bottom
    localparam int WIDE_EXTRA = 2;

    function automatic int pulses_for(input int n_ch, input int bits);
        return 1 + n_ch * bits;
    endfunction

endpackage

// File: rtl/adcgrp_seq.sv
module adcgrp_seq
    import adcgrp_pkg::*;
#(
    parameter int N_CH  = 4,
    parameter int OUT_W = 16
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    req_i,
    input  fmt_e    fmt_i,
    output logic    sclk_o,
    output logic    busy_o,
    output logic    ovr_o,
    output fmt_e    fmt_o,
    output strobe_t stb_o
);
    localparam int NARROW_PULSES = pulses_for(N_CH, OUT_W);
    localparam int WIDE_PULSES   = pulses_for(N_CH, OUT_W + WIDE_EXTRA);
    localparam int IDX_W         = $clog2(WIDE_PULSES);
    localparam logic [IDX_W-1:0] LAST_NARROW = IDX_W'(NARROW_PULSES - 1);
    localparam logic [IDX_W-1:0] LAST_WIDE   = IDX_W'(WIDE_PULSES - 1);

    seq_e             state_q;
    logic             sclk_q;
    logic             ovr_q;
    fmt_e             fmt_q;
    logic [IDX_W-1:0] idx_q;
    logic [IDX_W-1:0] last_idx;
    logic             running;

    assign running  = (state_q == SEQ_RUN);
    assign last_idx = (fmt_q == FMT_WIDE) ? LAST_WIDE : LAST_NARROW;

    always_comb begin
        stb_o.sample = running && sclk_q && (idx_q != '0);
        stb_o.last   = running && sclk_q && (idx_q == last_idx);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SEQ_IDLE;
            sclk_q  <= 1'b0;
            ovr_q   <= 1'b0;
            fmt_q   <= FMT_NARROW;
            idx_q   <= '0;
        end else begin
            ovr_q <= req_i && running;
            unique case (state_q)
                SEQ_IDLE: begin
                    if (req_i) begin
                        state_q <= SEQ_RUN;
                        sclk_q  <= 1'b1;
                        idx_q   <= '0;
                        fmt_q   <= fmt_i;
                    end
                end
                SEQ_RUN: begin
                    if (sclk_q) begin
                        sclk_q <= 1'b0;
                        if (idx_q == last_idx) begin
                            state_q <= SEQ_IDLE;
                        end
                    end else begin
                        sclk_q <= 1'b1;
                        idx_q  <= idx_q + IDX_W'(1);
                    end
                end
                default: state_q <= SEQ_IDLE;
            endcase
        end
    end

    assign sclk_o = sclk_q;
    assign busy_o = running;
    assign ovr_o  = ovr_q;
    assign fmt_o  = fmt_q;

endmodule

// File: rtl/adcgrp_capture.sv
module adcgrp_capture
    import adcgrp_pkg::*;
#(
    parameter int N_CH  = 4,
    parameter int OUT_W = 16
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  sdata_i,
    input  strobe_t               stb_i,
    input  fmt_e                  fmt_i,
    output logic                  valid_o,
    output logic [N_CH*OUT_W-1:0] data_o
);
    localparam int RAW_W = OUT_W + WIDE_EXTRA;
    localparam int SH_W  = N_CH * RAW_W;

    logic [SH_W-2:0]        shift_q;
    logic [SH_W-1:0]        shift_next;
    logic [N_CH*OUT_W-1:0]  words;
    logic [N_CH*OUT_W-1:0]  data_q;
    logic                   valid_q;

    assign shift_next = {shift_q, sdata_i};

    // Channel 0 arrives first, so it ends up in the highest slice of the shifter
    for (genvar c = 0; c < N_CH; c++) begin : g_chan
        localparam int NARROW_LO = (N_CH - 1 - c) * OUT_W;
        localparam int WIDE_LO   = (N_CH - 1 - c) * RAW_W + 1;
        assign words[c*OUT_W +: OUT_W] = (fmt_i == FMT_WIDE)
                                       ? shift_next[WIDE_LO +: OUT_W]
                                       : shift_next[NARROW_LO +: OUT_W];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            shift_q <= '0;
            data_q  <= '0;
            valid_q <= 1'b0;
        end else begin
            valid_q <= stb_i.last;
            if (stb_i.sample) begin
                shift_q <= shift_next[SH_W-2:0];
            end
            if (stb_i.last) begin
                data_q <= words;
            end
        end
    end

    assign valid_o = valid_q;
    assign data_o  = data_q;

endmodule

// File: rtl/adc_group_rx.sv
module adc_group_rx
    import adcgrp_pkg::*;
#(
    parameter int N_CH  = 4,
    parameter int OUT_W = 16
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  rd_req_i,
    input  logic                  wide_mode_i,
    input  logic                  sdata_i,
    output logic                  sclk_o,
    output logic                  busy_o,
    output logic                  pix_valid_o,
    output logic [N_CH*OUT_W-1:0] pix_data_o,
    output logic                  overrun_o
);
    fmt_e    fmt_req;
    fmt_e    fmt_live;
    strobe_t stb;

    assign fmt_req = fmt_e'(wide_mode_i);

    adcgrp_seq #(.N_CH(N_CH), .OUT_W(OUT_W)) u_seq (
        .clk    (clk),
        .rst    (rst),
        .req_i  (rd_req_i),
        .fmt_i  (fmt_req),
        .sclk_o (sclk_o),
        .busy_o (busy_o),
        .ovr_o  (overrun_o),
        .fmt_o  (fmt_live),
        .stb_o  (stb)
    );

    adcgrp_capture #(.N_CH(N_CH), .OUT_W(OUT_W)) u_cap (
        .clk     (clk),
        .rst     (rst),
        .sdata_i (sdata_i),
        .stb_i   (stb),
        .fmt_i   (fmt_live),
        .valid_o (pix_valid_o),
        .data_o  (pix_data_o)
    );

endmodule

// File: rtl/adc_group_rx_chk.sv
module adc_group_rx_chk
    import adcgrp_pkg::*;
#(
    parameter int N_CH  = 4,
    parameter int OUT_W = 16
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  rd_req_i,
    input logic                  wide_mode_i,
    input logic                  sclk_o,
    input logic                  busy_o,
    input logic                  pix_valid_o,
    input logic [N_CH*OUT_W-1:0] pix_data_o,
    input logic                  overrun_o
);
    localparam int NARROW_PULSES = pulses_for(N_CH, OUT_W);
    localparam int WIDE_PULSES   = pulses_for(N_CH, OUT_W + WIDE_EXTRA);
    localparam int CNT_W         = $clog2(WIDE_PULSES) + 1;

    logic [CNT_W-1:0] rises_q;
    logic             sclk_prev_q;
    logic             wide_seen_q;

    // Counts serial clock rising edges since the last accepted request
    always_ff @(posedge clk) begin
        if (rst) begin
            rises_q     <= '0;
            sclk_prev_q <= 1'b0;
            wide_seen_q <= 1'b0;
        end else begin
            sclk_prev_q <= sclk_o;
            if (rd_req_i && !busy_o) begin
                rises_q     <= '0;
                wide_seen_q <= wide_mode_i;
            end else if (sclk_o && !sclk_prev_q) begin
                rises_q <= rises_q + CNT_W'(1);
            end
        end
    end

    AST_SCLK_IDLE_LOW: assert property (@(posedge clk) disable iff (rst)
        !busy_o |-> !sclk_o);                                          // R2

    AST_SCLK_TOGGLES: assert property (@(posedge clk) disable iff (rst)
        (busy_o && $past(busy_o)) |-> (sclk_o != $past(sclk_o)));      // R2

    AST_PULSE_COUNT: assert property (@(posedge clk) disable iff (rst)
        pix_valid_o |-> (rises_q == (wide_seen_q ? CNT_W'(WIDE_PULSES)
                                                 : CNT_W'(NARROW_PULSES)))); // R3

    AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (rst)
        pix_valid_o |=> !pix_valid_o);                                 // R7

    AST_DATA_HOLD: assert property (@(posedge clk) disable iff (rst)
        !pix_valid_o |-> $stable(pix_data_o));                         // R7

    AST_OVERRUN_CAUSE: assert property (@(posedge clk) disable iff (rst)
        overrun_o |-> ($past(busy_o) && $past(rd_req_i)));             // R8

    AST_BUSY_ENDS_WITH_VALID: assert property (@(posedge clk) disable iff (rst)
        pix_valid_o |-> $fell(busy_o));                                // R10

endmodule

bind adc_group_rx adc_group_rx_chk #(.N_CH(N_CH), .OUT_W(OUT_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .rd_req_i    (rd_req_i),
    .wide_mode_i (wide_mode_i),
    .sclk_o      (sclk_o),
    .busy_o      (busy_o),
    .pix_valid_o (pix_valid_o),
    .pix_data_o  (pix_data_o),
    .overrun_o   (overrun_o)
);

// File: tb/sim_adc_group_rx.sv
`timescale 1ns/1ps
module sim_adc_group_rx;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rd_req = 1'b0;
    logic        wide_mode = 1'b0;
    logic        sdata = 1'b0;
    logic        sclk;
    logic        busy;
    logic        pix_valid;
    logic [63:0] pix_data;
    logic        overrun;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    // Converter model state
    logic stream [0:71];
    int   n_bits   = 0;
    int   rise_cnt = 0;

    always #4 clk = ~clk;

    adc_group_rx u0 (
        .clk         (clk),
        .rst         (rst),
        .rd_req_i    (rd_req),
        .wide_mode_i (wide_mode),
        .sdata_i     (sdata),
        .sclk_o      (sclk),
        .busy_o      (busy),
        .pix_valid_o (pix_valid),
        .pix_data_o  (pix_data),
        .overrun_o   (overrun)
    );

    // Converter model: launches the next bit on each rising serial edge,
    // a junk bit on the conversion pulse
    always @(posedge sclk) begin
        if (rise_cnt >= 1 && rise_cnt <= n_bits) sdata = stream[rise_cnt-1];
        else sdata = 1'b1;
        rise_cnt = rise_cnt + 1;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [63:0] exp_words(input bit wide, input logic [71:0] raws);
        logic [63:0] v = '0;
        for (int c = 0; c < 4; c++) begin
            logic [17:0] r = raws[c*18 +: 18];
            v[c*16 +: 16] = wide ? r[16:1] : r[15:0];
        end
        return v;
    endfunction

    task automatic load_stream(input bit wide, input logic [71:0] raws);
        int w = wide ? 18 : 16;
        int k = 0;
        for (int c = 0; c < 4; c++) begin
            logic [17:0] r = raws[c*18 +: 18];
            for (int b = w - 1; b >= 0; b--) begin
                stream[k] = r[b];
                k++;
            end
        end
        n_bits   = k;
        rise_cnt = 0;
    endtask

    // Called at a negedge; returns at the negedge where the strobe is seen
    task automatic run_frame(input bit wide, input logic [71:0] raws,
                             input int ovr_at, input int flip_at, input string dreq);
        int npulse = wide ? 73 : 65;
        int cyc = 0;
        logic [63:0] exp_v = exp_words(wide, raws);
        load_stream(wide, raws);
        wide_mode = wide;
        rd_req = 1'b1;
        @(negedge clk);
        rd_req = 1'b0;
        cyc = 1;
        chk(sclk && busy, "R2", "burst start sclk/busy", {62'd0, sclk, busy}, 64'd3);
        while (cyc < 400) begin
            if (pix_valid) break;
            rd_req = (cyc == ovr_at);
            if (cyc == flip_at) wide_mode = !wide;
            @(negedge clk);
            cyc++;
            if (ovr_at > 0 && cyc == ovr_at + 1)
                chk(overrun, "R8", "overrun flag after busy request", 64'(overrun), 64'd1);
        end
        rd_req = 1'b0;
        wide_mode = wide;
        chk(pix_valid && cyc == 2 * npulse, "R7", "strobe cycle", 64'(cyc), 64'(2 * npulse));
        chk(rise_cnt == npulse, "R3", "pulse count", 64'(rise_cnt), 64'(npulse));
        chk(!busy, "R10", "busy low at strobe", 64'(busy), 64'd0);
        chk(pix_data == exp_v, dreq, "channel words", pix_data, exp_v);
    endtask

    task automatic check_quiet(input logic [63:0] held);
        @(negedge clk);
        chk(!pix_valid && !overrun, "R7", "strobe single cycle", {62'd0, pix_valid, overrun}, 64'd0);
        chk(!busy && !sclk, "R8", "idle after frame, no extra burst", {62'd0, busy, sclk}, 64'd0);
        chk(pix_data == held, "R7", "words held", pix_data, held);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        logic [71:0] raws;
        logic [63:0] exp_v;
        void'($urandom(32'h5eed_1234));

        // R1: reset state
        repeat (3) @(negedge clk);
        chk({sclk, busy, pix_valid, overrun} == 4'b0 && pix_data == 64'd0, "R1",
            "outputs in reset", {59'd0, sclk, busy, pix_valid, overrun, |pix_data}, 64'd0);
        rst = 1'b0;
        @(negedge clk);
        chk({sclk, busy, pix_valid, overrun} == 4'b0 && pix_data == 64'd0, "R1",
            "outputs after reset", {59'd0, sclk, busy, pix_valid, overrun, |pix_data}, 64'd0);

        // R4 R5: narrow frame with distinct channel patterns
        raws = {18'h0_5555, 18'h0_AAAA, 18'h0_7FFE, 18'h0_8001};
        run_frame(1'b0, raws, 0, 0, "R4 R5");
        check_quiet(exp_words(1'b0, raws));

        // R6: wide frame, guard and dropped bits set against the kept ones
        raws = {18'h2_0001, 18'h1_FFFE, 18'h3_5555, 18'h0_AAAA};
        run_frame(1'b1, raws, 0, 0, "R6");
        check_quiet(exp_words(1'b1, raws));

        // R8: request in the middle of a burst
        raws = {18'h0_1234, 18'h0_5678, 18'h0_9ABC, 18'h0_DEF0};
        run_frame(1'b0, raws, 20, 0, "R8");
        check_quiet(exp_words(1'b0, raws));

        // R8 R7: request in the last cycle, overrun coincides with the strobe
        raws = {18'h1_1111, 18'h2_2222, 18'h3_3333, 18'h0_4444};
        run_frame(1'b1, raws, 2 * 73 - 1, 0, "R8");
        chk(overrun && pix_valid, "R8", "overrun with strobe", {62'd0, overrun, pix_valid}, 64'd3);
        check_quiet(exp_words(1'b1, raws));
        raws = {18'h0_0F0F, 18'h0_F0F0, 18'h0_00FF, 18'h0_FF00};
        run_frame(1'b0, raws, 2 * 65 - 1, 0, "R8");
        chk(overrun && pix_valid, "R8", "overrun with strobe narrow", {62'd0, overrun, pix_valid}, 64'd3);
        check_quiet(exp_words(1'b0, raws));

        // R9: format input flipped mid-burst
        raws = {18'h2_ABCD, 18'h1_2345, 18'h0_6789, 18'h3_0001};
        run_frame(1'b1, raws, 0, 30, "R9");
        check_quiet(exp_words(1'b1, raws));
        run_frame(1'b0, raws, 0, 30, "R9");
        check_quiet(exp_words(1'b0, raws));

        // R10: request in the strobe cycle starts a new burst at once
        raws = {18'h0_CAFE, 18'h0_BEEF, 18'h0_F00D, 18'h0_0BAD};
        run_frame(1'b0, raws, 0, 0, "R5");
        raws = {18'h3_FFFF, 18'h0_0000, 18'h2_8000, 18'h1_0001};
        run_frame(1'b1, raws, 0, 0, "R10");
        check_quiet(exp_words(1'b1, raws));

        // Random frames
        for (int i = 0; i < 24; i++) begin
            bit w = 1'($urandom());
            int ovr = ($urandom() % 4 == 0) ? int'(2 + $urandom() % 100) : 0;
            raws = {$urandom(), $urandom(), 8'($urandom())};
            exp_v = exp_words(w, raws);
            run_frame(w, raws, ovr, 0, w ? "R6" : "R5");
            check_quiet(exp_v);
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule